// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a 24-bit down counter that produces a periodic tick. It sits behind a small 32-bit register port with address, write data, read data and separate write and read strobes. Software programs a reload value and picks a tick source: the core-clock enable or a slower reference tick enable. It then turns the counter on. The counter steps toward zero on each selected tick and restarts from the reload value when it reaches zero. Each transition from one to zero can raise a one-cycle interrupt request. The same transition also sets a sticky flag, so polling code can tell that a programmed interval has elapsed since it last looked.

Four registers make up the map: control/status, reload, current count and a read-only calibration constant. The design does not generate the two tick enables. It takes them as inputs, each one cycle wide, so that clock generation stays outside the block.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current count registers all read zero, and the irq output is low.
- R2: Offsets 0x10 (control/status), 0x14 (reload), 0x18 (current count) and 0x1C (calibration) are decoded; any other address reads zero and writes there change nothing.
- R3: Control/status bit 0 is the run enable. While it is 0, the current count holds its value.
- R4: Control/status bit 2 chooses the tick source: 1 selects core_tick_en and 0 selects ref_tick_en. The count moves down by one only on a cycle where the selected enable is high.
- R5: A tick that finds the count at zero loads the reload value, so a reload of N gives a period of N+1 ticks.
- R6: Control/status bit 16 is a sticky flag. It sets when the count steps from 1 to 0. A read of control/status returns the flag and then clears it. If a step to zero falls in the same cycle as a control/status read, that read returns 0 in bit 16 and the flag is left set.
- R7: A write of any data to the current count register clears the count and the flag, and that cycle's tick is discarded. The next tick then loads the reload value.
- R8: While control/status bit 1 is set, each 1-to-0 step of the count drives irq high for exactly one cycle, aligned with the count reading zero. While bit 1 is clear, irq stays low.
- R9: With a reload of zero the count stays at zero, and neither the flag nor irq is raised.
- R10: The calibration register returns the parameter CAL_VALUE, and writes to it are ignored.
- R11: The reload and count fields are 24 bits wide (bits 23:0). Their upper bits read zero, and control/status bits other than 0, 1, 2 and 16 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge that ends the strobe cycle |
| bus_rdata | output | DATA_W (32) | Read data, combinational while bus_rd is high |
| core_tick_en | input | 1 | Core-clock tick enable |
| ref_tick_en | input | 1 | Reference tick enable |
| irq | output | 1 | Interrupt request pulse |

## Verification
Two events can land on the sticky flag in the same cycle: a step of the count to zero sets it, and a control/status read clears it. The bench sets a reload of 3 and counts cycles from the enabling write. It holds a control/status read across exactly the edge on which the count reaches zero, and expects bit 16 to read 0 during that read. A second read must then return bit 16 set, which shows the set was not lost to the clear. A second collision is a write to the current count while the counter is running. The bench expects the count to read zero right after the write, and to read the reload value one tick later.

// File: rtl/tick_pkg.sv
package tick_pkg;

    // register byte offsets inside the block
    localparam int unsigned OFF_CTRL   = 32'h10;
    localparam int unsigned OFF_RELOAD = 32'h14;
    localparam int unsigned OFF_CUR    = 32'h18;
    localparam int unsigned OFF_CAL    = 32'h1C;

    // control/status bit positions
    localparam int unsigned BIT_RUN  = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    typedef struct packed {
        logic run;
        logic ie;
        logic core_src;
    } ctrl_t;

endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel (
    input  logic core_tick,
    input  logic ref_tick,
    input  logic use_core,
    output logic tick
);
    always_comb begin
        tick = use_core ? core_tick : ref_tick;
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             ie,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cur,
    output logic             wrap,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cur;
        logic             irq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        wrap     = 1'b0;
        step     = run && tick && !clr;
        if (clr) begin
            st_d.cur = '0;
        end else if (step) begin
            if (st_q.cur == '0) begin
                st_d.cur = reload;
            end else begin
                st_d.cur = st_q.cur - 1'b1;
                if (st_q.cur == CNT_W'(1)) begin
                    wrap = 1'b1;
                end
            end
        end
        st_d.irq = wrap && ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur = st_q.cur;
    assign irq = st_q.irq;

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !clr && cur != '0) |=> cur == $past(cur) - 1'b1); // R4
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !clr && cur == '0) |=> cur == $past(reload)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(run && tick)) |=> $stable(cur)); // R3
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cur == '0 && !irq)); // R7
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cur == '0); // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 32,
    parameter int unsigned          CNT_W     = 24,
    parameter logic [DATA_W-1:0]    CAL_VALUE = 32'h0000_2710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cur,
    input  logic              wrap,
    output logic              run,
    output logic              ie,
    output logic              core_src,
    output logic [CNT_W-1:0]  reload,
    output logic              clr_cur
);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
    localparam logic [ADDR_W-1:0] A_CUR    = ADDR_W'(OFF_CUR);
    localparam logic [ADDR_W-1:0] A_CAL    = ADDR_W'(OFF_CAL);

    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic [CNT_W-1:0] reload;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_ctrl, wr_reload, rd_ctrl;
    logic    wdata_unused;

    assign wdata_unused = ^bus_wdata;

    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
        wr_reload = bus_wr && (bus_addr == A_RELOAD);
        clr_cur   = bus_wr && (bus_addr == A_CUR);
        rd_ctrl   = bus_rd && (bus_addr == A_CTRL);

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.run      = bus_wdata[BIT_RUN];
            st_d.ctrl.ie       = bus_wdata[BIT_IE];
            st_d.ctrl.core_src = bus_wdata[BIT_SRC];
        end
        if (wr_reload) begin
            st_d.reload = bus_wdata[CNT_W-1:0];
        end
        // priority: count write clears, a fresh step sets, a status read clears
        if (clr_cur) begin
            st_d.flag = 1'b0;
        end else if (wrap) begin
            st_d.flag = 1'b1;
        end else if (rd_ctrl) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL: begin
                    bus_rdata[BIT_RUN]  = st_q.ctrl.run;
                    bus_rdata[BIT_IE]   = st_q.ctrl.ie;
                    bus_rdata[BIT_SRC]  = st_q.ctrl.core_src;
                    bus_rdata[BIT_FLAG] = st_q.flag;
                end
                A_RELOAD: bus_rdata = DATA_W'(st_q.reload);
                A_CUR:    bus_rdata = DATA_W'(cur);
                A_CAL:    bus_rdata = CAL_VALUE;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign run      = st_q.ctrl.run;
    assign ie       = st_q.ctrl.ie;
    assign core_src = st_q.ctrl.core_src;
    assign reload   = st_q.reload;

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> st_q.flag); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !wrap) |=> !st_q.flag); // R6
    AST_CUR_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cur |=> !st_q.flag); // R7
    AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reload |=> $stable(st_q.reload)); // R2
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       CNT_W     = 24,
    parameter logic [DATA_W-1:0] CAL_VALUE = 32'h0000_2710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              core_tick_en,
    input  logic              ref_tick_en,
    output logic              irq
);
    logic             run, ie, core_src, clr_cur, tick, wrap;
    logic [CNT_W-1:0] reload, cur;

    tick_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .CAL_VALUE (CAL_VALUE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .cur       (cur),
        .wrap      (wrap),
        .run       (run),
        .ie        (ie),
        .core_src  (core_src),
        .reload    (reload),
        .clr_cur   (clr_cur)
    );

    tick_src_sel u_src (
        .core_tick (core_tick_en),
        .ref_tick  (ref_tick_en),
        .use_core  (core_src),
        .tick      (tick)
    );

    tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (run),
        .ie     (ie),
        .clr    (clr_cur),
        .reload (reload),
        .cur    (cur),
        .wrap   (wrap),
        .irq    (irq)
    );

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie)); // R8
    AST_ZERO_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0 && cur == '0) |=> !irq); // R9
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          WD_CYCLES  = 100000;
    localparam logic [31:0] EXP_CAL    = 32'h0001_86A0;
    localparam logic [7:0]  A_CTRL     = 8'h10;
    localparam logic [7:0]  A_RELOAD   = 8'h14;
    localparam logic [7:0]  A_CUR      = 8'h18;
    localparam logic [7:0]  A_CAL      = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        core_tick_en = 1'b1;
    logic        ref_tick_en = 1'b0;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer #(.CAL_VALUE(EXP_CAL)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .core_tick_en (core_tick_en),
        .ref_tick_en  (ref_tick_en),
        .irq          (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(A_CTRL, v);   check("R1 ctrl", v, 32'h0);
        bus_read(A_RELOAD, v); check("R1 reload", v, 32'h0);
        bus_read(A_CUR, v);    check("R1 cur", v, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, v);     check("R2 unmapped 0x00", v, 32'h0);
        bus_read(8'h20, v);     check("R2 unmapped 0x20", v, 32'h0);
        bus_write(A_RELOAD, 32'hFFFF_FFFF);
        bus_read(A_RELOAD, v);  check("R11 reload width", v, 32'h00FF_FFFF);
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        bus_read(A_CTRL, v);    check("R11 ctrl bits", v, 32'h0000_0007);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CUR, v);     check("R11 cur width", v & 32'hFF00_0000, 32'h0);
        bus_write(A_CAL, 32'h0);
        bus_read(A_CAL, v);     check("R10 calib", v, EXP_CAL);
    endtask

    task automatic t_period_irq;
        logic [31:0] v;
        bus_write(A_RELOAD, 32'd3);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h7);
        bus_addr = A_CUR; bus_rd = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            #1;
            check("R5 count sequence", bus_rdata, 32'(3 - ((k - 1) % 4)));
            check("R8 irq pulse", {31'b0, irq}, {31'b0, (k % 4) == 0});
        end
        bus_rd = 1'b0;
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, v);  check("R6 flag set", v, 32'h0001_0000);
        bus_read(A_CTRL, v);  check("R6 flag cleared by read", v, 32'h0);
        bus_read(A_CUR, v);   check("R3 stopped value", v, 32'd2);
        repeat (5) @(negedge clk);
        bus_read(A_CUR, v);   check("R3 holds while off", v, 32'd2);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        bus_write(A_CUR, 32'h0);
        bus_write(A_RELOAD, 32'd3);
        bus_write(A_CTRL, 32'h5);
        repeat (3) @(negedge clk);
        bus_addr = A_CTRL; bus_rd = 1'b1;
        #1 check("R6 read during step", bus_rdata, 32'h5);
        @(negedge clk);
        bus_rd = 1'b0;
        bus_read(A_CTRL, v);  check("R6 set wins over clear", v, 32'h0001_0005);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_irq_off;
        logic [31:0] v;
        bus_write(A_CUR, 32'h0);
        bus_write(A_RELOAD, 32'd2);
        bus_write(A_CTRL, 32'h5);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            #1 check("R8 no irq when disabled", {31'b0, irq}, 32'h0);
        end
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, v);  check("R6 flag without irq", v, 32'h0001_0000);
    endtask

    task automatic t_source;
        logic [31:0] v;
        bus_write(A_CUR, 32'h0);
        bus_write(A_RELOAD, 32'd5);
        core_tick_en = 1'b1; ref_tick_en = 1'b0;
        bus_write(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        bus_read(A_CUR, v);   check("R4 core tick ignored on ref source", v, 32'h0);
        ref_tick_en = 1'b1;
        @(negedge clk);
        ref_tick_en = 1'b0;
        bus_read(A_CUR, v);   check("R4 ref tick loads", v, 32'd5);
        ref_tick_en = 1'b1;
        @(negedge clk);
        ref_tick_en = 1'b0;
        bus_read(A_CUR, v);   check("R4 ref tick decrements", v, 32'd4);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_cur_write;
        logic [31:0] v;
        bus_write(A_RELOAD, 32'd1);
        bus_write(A_CTRL, 32'h5);
        repeat (5) @(negedge clk);
        bus_write(A_CTRL, 32'h0);
        bus_write(A_CUR, 32'h00AB_CDEF);
        bus_read(A_CUR, v);   check("R7 count cleared", v, 32'h0);
        bus_read(A_CTRL, v);  check("R7 flag cleared", v, 32'h0);
        bus_write(A_RELOAD, 32'd3);
        bus_write(A_CTRL, 32'h5);
        repeat (2) @(negedge clk);
        bus_write(A_CUR, 32'h1);
        bus_read(A_CUR, v);   check("R7 next tick loads reload", v, 32'd3);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_reload_zero;
        logic [31:0] v;
        bus_write(A_CUR, 32'h0);
        bus_write(A_RELOAD, 32'h0);
        bus_write(A_CTRL, 32'h7);
        bus_addr = A_CUR; bus_rd = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            #1;
            check("R9 count stays zero", bus_rdata, 32'h0);
            check("R9 no irq", {31'b0, irq}, 32'h0);
        end
        bus_rd = 1'b0;
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CTRL, v);  check("R9 no flag", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_period_irq();
        t_same_cycle();
        t_irq_off();
        t_source();
        t_cur_write();
        t_reload_zero();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule